// File: doc/BRIEF.md
# Stereo Switch-Tuned Sine Tone Source

This block produces a sine tone on each of the two channels of a stereo pair and hands both as signed 16-bit sample words to a downstream DAC controller. The DAC controller pulses a sample request once per audio sample period. On each request the block looks up the current table position of each channel, registers the two words, and raises a one-cycle valid strobe on the following cycle. It then advances each channel's table position.

Each channel has its own four-switch field that sets the pitch, and its own pushbutton that silences it while held. Switch and button inputs come straight from the board. They pass through two-flop synchronizers before they are used. A silenced channel keeps stepping through the table, so the tone resumes at the right point in the waveform when the button is released. The reset input clears asynchronously, and its release is synchronized to the clock inside the block.

Top module: `tonegen_top`

## Requirements
- R1: While reset is held, and after its release until the first request, `left_o`, `right_o` and `valid_o` are all zero.
- R2: `valid_o` is high in exactly the cycles whose preceding clock edge sampled `sample_req_i` high. It is never high otherwise. A request held high for N cycles therefore yields N consecutive valid cycles.
- R3: The waveform is a table of 64 entries spanning one period. Entry k holds round(32767·sin(2πk/64)), rounded half away from zero and stored as signed 16-bit. The first sample after reset on each channel is entry 0.
- R4: The left channel pitch field is `switch_i[7:4]`, read as an unsigned value v. Each request moves the left table position forward by v+1, modulo 64. A field of 0 still advances by one entry.
- R5: The right channel pitch field is `switch_i[3:0]`, using the same step rule as R4 and independent of the left field.
- R6: While `button_i[0]` is high, every left sample word is exactly zero. The right channel is unaffected.
- R7: While `button_i[1]` is high, every right sample word is exactly zero. The left channel is unaffected.
- R8: A muted channel keeps advancing its table position on every request. After release, its output continues from the position it would have reached unmuted.
- R9: Between requests, the table positions do not move, and `left_o` and `right_o` keep the last words produced.
- R10: A switch or button change that is held steady takes effect for every request sampled from the third clock edge after the change onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_req_i | input | 1 | Sample request strobe from the DAC controller, synchronous to clk |
| switch_i | input | 8 | Pitch switches: [7:4] left, [3:0] right |
| button_i | input | 2 | Mute buttons: [0] left, [1] right |
| left_o | output | 16 | Left channel signed sample word |
| right_o | output | 16 | Right channel signed sample word |
| valid_o | output | 1 | One-cycle strobe marking new sample words |

## Verification
The bench builds the block with its defaults: 16-bit samples, a 64-entry table and 4-bit pitch fields. With these values, a field of 15 steps by 16 entries, so table position wrap-around occurs after only four requests. The smallest field visits every entry in turn. Both channels run at different pitches at the same time, so a swapped field or button shows up at once. Mute press and release are placed mid-sequence to expose a channel whose phase froze while silenced. Held multi-cycle requests and long idle gaps exercise the strobe rule and the hold behaviour.

// File: rtl/tonegen_pkg.sv
package tonegen_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Signed sine value for table slot idx of a depth-entry period, peak amp.
  function automatic int sine_entry(input int idx, input int depth, input int amp);
    real r;
    r = real'(amp) * $sin(TWO_PI * real'(idx) / real'(depth));
    return int'(r);
  endfunction

endpackage

// File: rtl/tonegen_sync.sv
module tonegen_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] out_q, out_d;

  always_comb begin
    meta_d = d_i;
    out_d  = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      out_q  <= '0;
    end else begin
      meta_q <= meta_d;
      out_q  <= out_d;
    end
  end

  assign q_o = out_q;

endmodule

// File: rtl/tonegen_phase.sv
module tonegen_phase #(
  parameter int IDX_W  = 6,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic [STEP_W-1:0] field_i,
  output logic [IDX_W-1:0]  idx_o
);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] step;

  always_comb begin
    step  = IDX_W'(field_i) + IDX_W'(1);
    idx_d = idx_q;
    if (adv_i) idx_d = idx_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx_o = idx_q;

endmodule

// File: rtl/tonegen_sine.sv
module tonegen_sine #(
  parameter int IDX_W    = 6,
  parameter int SAMPLE_W = 16
) (
  input  logic [IDX_W-1:0]           idx_i,
  output logic signed [SAMPLE_W-1:0] val_o
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int AMP   = (1 << (SAMPLE_W - 1)) - 1;

  logic signed [SAMPLE_W-1:0] rom [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    localparam int VAL = tonegen_pkg::sine_entry(k, DEPTH, AMP);
    assign rom[k] = SAMPLE_W'(VAL);
  end

  assign val_o = rom[idx_i];

endmodule

// File: rtl/tonegen_top.sv
module tonegen_top #(
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 6,
  parameter int FIELD_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sample_req_i,
  input  logic [2*FIELD_W-1:0]      switch_i,
  input  logic [1:0]                button_i,
  output logic signed [SAMPLE_W-1:0] left_o,
  output logic signed [SAMPLE_W-1:0] right_o,
  output logic                      valid_o
);

  localparam int NCH = 2;

  // reset: asynchronous assertion, synchronized release
  logic [1:0] rst_sh_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_q_n = rst_sh_q[1];

  // input synchronizers
  logic [2*FIELD_W-1:0] sw_s;
  logic [NCH-1:0]       btn_s;

  tonegen_sync #(.W(2*FIELD_W)) u_sw_sync (
    .clk(clk), .rst_n(rst_q_n), .d_i(switch_i), .q_o(sw_s)
  );
  tonegen_sync #(.W(NCH)) u_btn_sync (
    .clk(clk), .rst_n(rst_q_n), .d_i(button_i), .q_o(btn_s)
  );

  // per-channel phase and lookup; channel 0 = left, 1 = right
  logic [IDX_W-1:0]           phase [NCH];
  logic signed [SAMPLE_W-1:0] wave  [NCH];
  logic signed [SAMPLE_W-1:0] smp_d [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tonegen_phase #(.IDX_W(IDX_W), .STEP_W(FIELD_W)) u_phase (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .adv_i  (sample_req_i),
      .field_i(sw_s[(NCH-1-c)*FIELD_W +: FIELD_W]),
      .idx_o  (phase[c])
    );
    tonegen_sine #(.IDX_W(IDX_W), .SAMPLE_W(SAMPLE_W)) u_sine (
      .idx_i(phase[c]),
      .val_o(wave[c])
    );
    assign smp_d[c] = btn_s[c] ? '0 : wave[c];
  end

  // output registers
  logic signed [SAMPLE_W-1:0] left_q, left_d, right_q, right_d;
  logic                       valid_q, valid_d;

  always_comb begin
    left_d  = left_q;
    right_d = right_q;
    valid_d = sample_req_i;
    if (sample_req_i) begin
      left_d  = smp_d[0];
      right_d = smp_d[1];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
    end else begin
      left_q  <= left_d;
      right_q <= right_d;
      valid_q <= valid_d;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/tonegen_checker.sv
module tonegen_checker #(
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 6
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic                req,
  input logic [1:0]          btn_s,
  input logic [SAMPLE_W-1:0] left,
  input logic [SAMPLE_W-1:0] right,
  input logic                valid,
  input logic [IDX_W-1:0]    ph_l,
  input logic [IDX_W-1:0]    ph_r
);

  assert_valid_after_req_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    req |=> valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req |=> !valid);

  assert_left_muted_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req && btn_s[0]) |=> (left == '0));

  assert_right_muted_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req && btn_s[1]) |=> (right == '0));

  assert_phase_hold_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req |=> ($stable(ph_l) && $stable(ph_r)));

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req |=> ($stable(left) && $stable(right)));

  always @(posedge clk) begin
    if (!rst_q_n) begin
      assert_reset_state_R1: assert (valid == 1'b0);
    end
  end

endmodule

bind tonegen_top tonegen_checker #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_chk (
  .clk    (clk),
  .rst_q_n(rst_q_n),
  .req    (sample_req_i),
  .btn_s  (btn_s),
  .left   (left_o),
  .right  (right_o),
  .valid  (valid_o),
  .ph_l   (phase[0]),
  .ph_r   (phase[1])
);

// File: tb/tonegen_top_bench.sv
module tonegen_top_bench;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req = 1'b0;
  logic [7:0]         sw = '0;
  logic [1:0]         btn = '0;
  logic signed [15:0] left, right;
  logic               valid;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic signed [15:0] l;
    logic signed [15:0] r;
    string              tag;
  } item_t;

  item_t exp_q[$];

  int ph_l = 0, ph_r = 0;
  logic signed [15:0] last_l = '0, last_r = '0;

  always #10 clk = ~clk;

  tonegen_top u_tonegen_top (
    .clk(clk), .rst_n(rst_n), .sample_req_i(req), .switch_i(sw),
    .button_i(btn), .left_o(left), .right_o(right), .valid_o(valid)
  );

  function automatic logic signed [15:0] ref_sine(input int k);
    real r;
    int  v;
    r = 32767.0 * $sin(6.283185307179586 * real'(k) / 64.0);
    if (r >= 0.0) v = $rtoi(r + 0.5);
    else          v = -$rtoi(-r + 0.5);
    return 16'(v);
  endfunction

  task automatic check(input string tag, input logic signed [15:0] act,
                       input logic signed [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: push expected items, hold request for n cycles
  task automatic request(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.l = btn[0] ? 16'sd0 : ref_sine(ph_l);
      it.r = btn[1] ? 16'sd0 : ref_sine(ph_r);
      it.tag = tag;
      exp_q.push_back(it);
      last_l = it.l;
      last_r = it.r;
      ph_l = (ph_l + int'(sw[7:4]) + 1) % 64;
      ph_r = (ph_r + int'(sw[3:0]) + 1) % 64;
    end
    @(negedge clk); req = 1'b1;
    repeat (n) @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n && valid) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected valid", 16'(valid), 16'd0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check({it.tag, " left"}, left, it.l);
          check({it.tag, " right"}, right, it.r);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 left in reset", left, 16'sd0);
    check("R1 valid in reset", 16'(valid), 16'd0);
    @(negedge clk); rst_n = 1'b1;
    idle(5);
    check("R1 left after release", left, 16'sd0);
    check("R1 right after release", right, 16'sd0);
    check("R1 valid after release", 16'(valid), 16'd0);

    // R3 R4 R5: left field 0, right field 5, single requests
    sw = 8'h05; idle(4);
    for (int i = 0; i < 12; i++) begin
      request(1, "R3 R4 R5 base");
      idle(3);
    end

    // R9: long gap, outputs hold
    idle(20);
    check("R9 left hold", left, last_l);
    check("R9 right hold", right, last_r);

    // R4 R5 wrap with largest fields, R10 new field after sync
    sw = 8'hF7; idle(3);
    for (int i = 0; i < 8; i++) begin
      request(1, "R4 R5 R10 wide step");
      idle(2);
    end

    // R2: held request gives consecutive valids
    request(4, "R2 held request");
    idle(4);
    check("R2 queue drained", 16'(exp_q.size()), 16'd0);

    // R6 R8: mute left, phase keeps going
    btn = 2'b01; idle(3);
    for (int i = 0; i < 6; i++) begin
      request(1, "R6 R8 left muted");
      idle(1);
    end
    btn = 2'b00; idle(3);
    for (int i = 0; i < 4; i++) begin
      request(1, "R8 left resumed");
      idle(1);
    end

    // R7 R8: mute right, new fields
    sw = 8'h3A; btn = 2'b10; idle(3);
    for (int i = 0; i < 6; i++) begin
      request(1, "R7 R8 right muted");
      idle(2);
    end
    btn = 2'b00; idle(3);
    request(3, "R8 right resumed");
    idle(3);

    // both muted
    btn = 2'b11; idle(3);
    request(2, "R6 R7 both muted");
    idle(3);
    btn = 2'b00; idle(3);
    request(2, "R8 both resumed");
    idle(10);
    check("R9 final hold left", left, last_l);
    check("R2 final queue drained", 16'(exp_q.size()), 16'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule